// File: doc/BRIEF.md
# Handshaked Integer Arithmetic Unit

This block is a small clocked arithmetic-logic unit that works on two unsigned 8-bit operands. A requester places the operands and a 3-bit function code on the inputs and raises `start_i`. The unit answers with a 16-bit result and a one-cycle `done_o` pulse. Addition, bitwise AND and bitwise XOR finish on the first clock edge. Multiplication runs as an iterative shift-add over several edges. All of these use the same handshake, so the requester simply holds `start_i` until it sees `done_o`.

The no-operation code produces no result and no completion, and the requester may drop `start_i` after one clock. The code that the surrounding environment uses to mean "reset" is handled the same way as a no-operation inside the unit. The two unused codes are handled that way as well. The only real reset is the asynchronous active-low `rst_ni`. Once a completion has been signalled, the unit accepts a new operation only after it has sampled `start_i` low.

Top module: `mini_alu`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0, `result_o` is 0 and the unit is idle. This holds even if reset arrives in the middle of a multiply.
- R2: Code 3'b001 (add) yields `result_o = A + B`, 16 bits wide, with the carry in bit 8.
- R3: Codes 3'b010 (AND) and 3'b011 (XOR) yield the bitwise result of the 8-bit operands, zero-extended, so bits 15:8 are 0.
- R4: For add, AND and XOR, `done_o` is high in the cycle that directly follows the rising edge that first samples `start_i` high.
- R5: Code 3'b100 (multiply) yields the full 16-bit product A*B. `done_o` is low after the first two edges and high after the third edge, counting the edge that first samples `start_i` high.
- R6: `done_o` is a single-cycle pulse. `result_o` changes only in the cycle where `done_o` is high and otherwise holds its value.
- R7: The operands and the function code are captured at the accepting edge. Changing them while a multiply is in progress does not affect its result or its timing.
- R8: After a completion, holding `start_i` high produces no further `done_o`. A new operation is accepted only after `start_i` has been sampled low at one edge at least.
- R9: Codes 3'b000 (no-op), 3'b111 (reset request) and the unused codes 3'b101 and 3'b110 produce no `done_o` and leave `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| op_i | input | 3 | Function code |
| start_i | input | 1 | Request strobe, held until `done_o` |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Result register |

## Verification
Add, AND and XOR are swept over every value of A against sixteen values of B, including 0x00 and 0xFF. Multiply is swept over the same grid, so a carry dropped out of bit 7 shows up, as does a logic result with stray upper bits or a shift-add step that misplaces a partial product. Each operation has its completion edge pinned exactly, so a multiply that finishes one edge early or late is reported. A multiply is run while its inputs are changed in flight, which catches a unit that reads live inputs instead of captured ones. A held `start_i` is kept high past completion, which exposes a unit that retriggers. The inert codes and a reset in the middle of a multiply are applied to show that they neither pulse `done_o` nor disturb the result register.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'b000,
    OP_ADD  = 3'b001,
    OP_AND  = 3'b010,
    OP_XOR  = 3'b011,
    OP_MUL  = 3'b100,
    OP_RSV5 = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSTQ = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_SINGLE,
    CLS_MUL
  } op_class_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_AND,
    FN_XOR
  } logic_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_WAIT_LOW
  } alu_state_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [2:0] op_i,
  output op_class_e  cls_o,
  output logic_fn_e  fn_o
);

  always_comb begin
    cls_o = CLS_NONE;
    fn_o  = FN_ADD;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin cls_o = CLS_SINGLE; fn_o = FN_ADD; end
      OP_AND: begin cls_o = CLS_SINGLE; fn_o = FN_AND; end
      OP_XOR: begin cls_o = CLS_SINGLE; fn_o = FN_XOR; end
      OP_MUL: cls_o = CLS_MUL;
      // no-op, reset request and unused codes are inert
      default: cls_o = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic_fn_e           fn_i,
  output logic [2*DATA_W-1:0] res_o
);

  logic [DATA_W:0] sum;

  assign sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = {{(DATA_W-1){1'b0}}, sum};
      FN_AND:  res_o = {{DATA_W{1'b0}}, a_i & b_i};
      default: res_o = {{DATA_W{1'b0}}, a_i ^ b_i};
    endcase
  end

endmodule

// File: rtl/alu_mul_seq.sv
module alu_mul_seq #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MUL_LAT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic                last_o,
  output logic [2*DATA_W-1:0] prod_o
);

  localparam int unsigned CH     = (DATA_W + MUL_LAT - 1) / MUL_LAT;
  localparam int unsigned PADW   = CH * MUL_LAT;
  localparam int unsigned ACC_W  = 2 * DATA_W;
  localparam int unsigned PART_W = DATA_W + CH;
  localparam int unsigned STEP_W = (MUL_LAT > 1) ? $clog2(MUL_LAT) : 1;

  logic                running;
  logic [STEP_W-1:0]   step;
  logic [DATA_W-1:0]   mcand;
  logic [PADW-1:0]     mplier;
  logic [ACC_W-1:0]    acc;

  logic [DATA_W-1:0]   src_mcand;
  logic [PADW-1:0]     src_mplier;
  logic [STEP_W-1:0]   cur_step;
  logic [CH-1:0]       chunk;
  logic [PART_W-1:0]   partial;
  logic [ACC_W-1:0]    shifted;
  logic [ACC_W-1:0]    acc_nxt;
  logic                active;

  // the load cycle already consumes the first multiplier chunk
  assign src_mcand  = load_i ? a_i : mcand;
  assign src_mplier = load_i ? PADW'(b_i) : mplier;
  assign cur_step   = load_i ? '0 : step;
  assign chunk      = src_mplier[CH-1:0];
  assign active     = load_i | running;

  always_comb begin
    partial = '0;
    for (int i = 0; i < int'(CH); i++) begin
      if (chunk[i]) partial = partial + (PART_W'(src_mcand) << i);
    end
  end

  assign shifted = ACC_W'(partial) << (int'(cur_step) * int'(CH));
  assign acc_nxt = (load_i ? '0 : acc) + shifted;
  assign last_o  = active && (cur_step == STEP_W'(MUL_LAT - 1));
  assign prod_o  = acc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running <= 1'b0;
      step    <= '0;
      mcand   <= '0;
      mplier  <= '0;
      acc     <= '0;
    end else if (active) begin
      acc     <= acc_nxt;
      mcand   <= src_mcand;
      mplier  <= src_mplier >> CH;
      running <= !last_o;
      step    <= last_o ? '0 : cur_step + STEP_W'(1);
    end
  end

  p_load_when_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !running);

  p_last_ends_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !running);

endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MUL_LAT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  op_class_e           cls_i,
  input  logic [2*DATA_W-1:0] logic_res_i,
  input  logic                mul_last_i,
  input  logic [2*DATA_W-1:0] mul_prod_i,
  output logic                mul_load_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] result_o
);

  localparam int unsigned AGE_W = $clog2(MUL_LAT + 1);

  alu_state_e       state;
  logic [AGE_W-1:0] mul_age;

  assign mul_load_o = (state == ST_IDLE) && start_i && (cls_i == CLS_MUL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            unique case (cls_i)
              CLS_SINGLE: begin
                result_o <= logic_res_i;
                done_o   <= 1'b1;
                state    <= ST_WAIT_LOW;
              end
              CLS_MUL: begin
                if (mul_last_i) begin
                  result_o <= mul_prod_i;
                  done_o   <= 1'b1;
                  state    <= ST_WAIT_LOW;
                end else begin
                  state <= ST_MUL;
                end
              end
              default: state <= ST_WAIT_LOW;
            endcase
          end
        end
        ST_MUL: begin
          if (mul_last_i) begin
            result_o <= mul_prod_i;
            done_o   <= 1'b1;
            state    <= ST_WAIT_LOW;
          end
        end
        default: begin
          if (!start_i) state <= ST_IDLE;
        end
      endcase
    end
  end

  // cycle counter used by the latency property
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mul_age <= '0;
    else if (mul_load_o)   mul_age <= AGE_W'(1);
    else if (state == ST_MUL) mul_age <= mul_age + AGE_W'(1);
    else                   mul_age <= '0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (!done_o && result_o == '0);
    end
  end

  p_single_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && start_i && cls_i == CLS_SINGLE) |=> done_o);

  p_mul_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_MUL && mul_last_i) |-> (mul_age == AGE_W'(MUL_LAT - 1)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_no_retrigger_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT_LOW) |=> !done_o);

  p_inert_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && start_i && cls_i == CLS_NONE) |=> !done_o);

endmodule

// File: rtl/mini_alu.sv
module mini_alu
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MUL_LAT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [2:0]          op_i,
  input  logic                start_i,
  output logic                done_o,
  output logic [2*DATA_W-1:0] result_o
);

  localparam int unsigned RES_W = 2 * DATA_W;

  op_class_e        cls;
  logic_fn_e        fn;
  logic [RES_W-1:0] logic_res;
  logic [RES_W-1:0] mul_prod;
  logic             mul_last;
  logic             mul_load;

  alu_op_decode u_decode (
    .op_i  (op_i),
    .cls_o (cls),
    .fn_o  (fn)
  );

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (fn),
    .res_o (logic_res)
  );

  alu_mul_seq #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mul_load),
    .a_i    (a_i),
    .b_i    (b_i),
    .last_o (mul_last),
    .prod_o (mul_prod)
  );

  alu_ctrl #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cls_i       (cls),
    .logic_res_i (logic_res),
    .mul_last_i  (mul_last),
    .mul_prod_i  (mul_prod),
    .mul_load_o  (mul_load),
    .done_o      (done_o),
    .result_o    (result_o)
  );

endmodule

// File: tb/mini_alu_tb.sv
module mini_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MUL_CYC    = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic [2:0]  op_i = '0;
  logic        start_i = 1'b0;
  logic        done_o;
  logic [15:0] result_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;
  logic [15:0] last_res = '0;

  mini_alu u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .start_i  (start_i),
    .done_o   (done_o),
    .result_o (result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // drives one request, checks latency, result, pulse width and retrigger
  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op, input int hold_extra);
    logic [15:0] exp;
    bit          makes;
    int          lat;
    string       rtag;
    makes = 1;
    lat   = 1;
    case (op)
      3'b001: begin exp = 16'(a) + 16'(b); rtag = "R2"; end
      3'b010: begin exp = {8'h00, a & b}; rtag = "R3"; end
      3'b011: begin exp = {8'h00, a ^ b}; rtag = "R3"; end
      3'b100: begin exp = 16'(a) * 16'(b); rtag = "R5"; lat = MUL_CYC; end
      default: begin exp = last_res; makes = 0; rtag = "R9"; end
    endcase
    @(negedge clk_i);
    a_i = a; b_i = b; op_i = op; start_i = 1'b1;
    if (makes) begin
      for (int c = 1; c <= lat; c++) begin
        @(negedge clk_i);
        if (c < lat) chk(done_o == 1'b0, "R5 early done", 32'(done_o), 0);
        else begin
          chk(done_o == 1'b1, (lat == 1) ? "R4 done timing" : "R5 done timing", 32'(done_o), 1);
          chk(result_o == exp, rtag, 32'(result_o), 32'(exp));
        end
      end
      last_res = exp;
      for (int h = 0; h < hold_extra; h++) begin
        @(negedge clk_i);
        chk(done_o == 1'b0 && result_o == last_res, "R8 held start", {15'd0, done_o, result_o}, {16'd0, last_res});
      end
      start_i = 1'b0;
      @(negedge clk_i);
      chk(done_o == 1'b0 && result_o == last_res, "R6 pulse/hold", {15'd0, done_o, result_o}, {16'd0, last_res});
    end else begin
      @(negedge clk_i);
      chk(done_o == 1'b0, "R9 no done", 32'(done_o), 0);
      start_i = 1'b0;
      for (int c = 0; c < 2; c++) begin
        @(negedge clk_i);
        chk(done_o == 1'b0 && result_o == last_res, "R9 quiet", {15'd0, done_o, result_o}, {16'd0, last_res});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0 && result_o == 16'h0, "R1 reset state", {15'd0, done_o, result_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4: logic ops over all A and a spread of B
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) begin
        run_op(8'(a), 8'(b), 3'b001, 0);
        run_op(8'(a), 8'(b), 3'b010, 0);
        run_op(8'(a), 8'(b), 3'b011, 0);
      end
    end

    // R5: multiply over the same grid
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) run_op(8'(a), 8'(b), 3'b100, 0);
    end
    run_op(8'hFF, 8'hFF, 3'b100, 0);

    // R9: inert codes, result must keep the previous value
    run_op(8'h12, 8'h34, 3'b001, 0);
    run_op(8'hFF, 8'hFF, 3'b000, 0);
    run_op(8'hFF, 8'hFF, 3'b101, 0);
    run_op(8'hFF, 8'hFF, 3'b110, 0);
    run_op(8'hFF, 8'hFF, 3'b111, 0);

    // R8: start held after completion, then a fresh request
    run_op(8'hF0, 8'h0F, 3'b011, 4);
    run_op(8'h20, 8'h30, 3'b100, 3);
    run_op(8'h80, 8'h80, 3'b001, 0);

    // R7: inputs altered during a multiply
    @(negedge clk_i);
    a_i = 8'd200; b_i = 8'd150; op_i = 3'b100; start_i = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 early", 32'(done_o), 0);
    a_i = 8'd1; b_i = 8'd2; op_i = 3'b001;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 early", 32'(done_o), 0);
    a_i = 8'd7; b_i = 8'd9; op_i = 3'b010;
    @(negedge clk_i);
    chk(done_o == 1'b1 && result_o == 16'd30000, "R7 captured operands", {15'd0, done_o, result_o}, {15'd0, 1'b1, 16'd30000});
    start_i = 1'b0;
    @(negedge clk_i);

    // R1: reset in the middle of a multiply
    a_i = 8'd99; b_i = 8'd77; op_i = 3'b100; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni  = 1'b0;
    #1;
    chk(done_o == 1'b0 && result_o == 16'h0, "R1 mid-op reset", {15'd0, done_o, result_o}, 0);
    repeat (3) begin
      @(negedge clk_i);
      chk(done_o == 1'b0 && result_o == 16'h0, "R1 held reset", {15'd0, done_o, result_o}, 0);
    end
    rst_ni = 1'b1;
    last_res = 16'h0;
    @(negedge clk_i);
    chk(done_o == 1'b0 && result_o == 16'h0, "R1 after release", {15'd0, done_o, result_o}, 0);
    run_op(8'hAB, 8'hCD, 3'b100, 0);
    run_op(8'hFF, 8'h01, 3'b001, 0);

    finish_run();
  end

endmodule